// File: doc/BRIEF.md
# I2C Target Clock Stretch Controller

This block holds the SCL line of an I2C target low between bytes so that the local CPU has time to respond. When the byte shift logic reports that a byte has finished, the block does three things. It clears its release bit, it raises a sticky interrupt flag, and it pulls SCL low through an open-drain enable. The remote controller sees SCL held low and cannot issue its next clock pulse. The hold has no time limit.

While SCL is held, the CPU loads the next transmit byte into the buffer and then writes the release bit to one. That write removes the pull-low, and the remote controller can clock the bus again. If the line is still high when a hold is requested, the block waits until the synchronized SCL input reads low before it pulls. This keeps the block from creating a clock edge of its own. The CPU can also start a hold by writing the release bit to zero.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: While rst_ni is low, scl_oe_o is 0, irq_o is 0, rel_o is 1 and tx_data_o is all zeros.
- R2: When byte_done_i is high at a clock edge and the synchronized SCL reads low, after that edge scl_oe_o is 1, rel_o is 0 and irq_o is 1.
- R3: Once scl_oe_o is 1, it stays 1 for any number of cycles until a release write (rel_we_i=1, rel_wdata_i=1) arrives. No timeout applies.
- R4: A release write during a hold, with byte_done_i low, makes scl_oe_o 0 and rel_o 1 after that edge.
- R5: irq_o stays 1 until irq_clr_i is pulsed. A clear makes irq_o 0 after that edge and leaves scl_oe_o unchanged.
- R6: If byte_done_i and a release write fall on the same edge, byte_done_i wins: after the edge rel_o is 0 and a hold is in force.
- R7: If byte_done_i and irq_clr_i fall on the same edge, irq_o is 1 after the edge.
- R8: If the synchronized SCL reads high when a hold is requested, rel_o goes to 0 at once but scl_oe_o stays 0. scl_oe_o rises on the edge after SCL has passed low through the SYNC_STAGES-flop synchronizer, which with the default of 2 is the third edge after scl_i falls.
- R9: A buffer write (buf_we_i) updates tx_data_o only while rel_o is 0. While rel_o is 1 the write is ignored and tx_data_o keeps its value.
- R10: Writing rel_wdata_i=0 while released starts a hold by the same rules as R2 and R8, and it leaves irq_o unchanged.
- R11: Writing rel_wdata_i=0 during a hold has no effect: scl_oe_o stays 1 and rel_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL bus level |
| byte_done_i | input | 1 | One-cycle strobe from shift logic at byte end |
| buf_we_i | input | 1 | CPU write strobe for the transmit buffer |
| buf_wdata_i | input | DATA_W | Transmit byte written by the CPU |
| rel_we_i | input | 1 | CPU write strobe for the release bit |
| rel_wdata_i | input | 1 | Value written to the release bit |
| irq_clr_i | input | 1 | CPU clear of the interrupt flag |
| scl_oe_o | output | 1 | Open-drain pull-low enable for SCL |
| rel_o | output | 1 | Current release bit |
| irq_o | output | 1 | Sticky byte-complete interrupt flag |
| tx_data_o | output | DATA_W | Transmit buffer contents for the shift logic |

## Verification
Two pairs of functions can land on the same edge.

- **Release and byte end.** The end-of-byte strobe can coincide with a CPU release write. The bench drives both strobes in one cycle. It judges the result on the following cycle: the pull-low must be in force and the release bit must read zero.
- **Flag clear and byte end.** The end-of-byte strobe can coincide with a flag clear. The bench pulses both together. It expects the flag to read one afterwards, since a new byte must never be lost behind a clear.

// File: rtl/i2cs_stretch_pkg.sv
package i2cs_stretch_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,  // SCL released
    ST_ARM  = 2'd1,  // hold requested, waiting for SCL low
    ST_HOLD = 2'd2   // pulling SCL low
  } hold_st_e;
endpackage

// File: rtl/i2cs_scl_sync.sv
module i2cs_scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic scl_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b1;
        else         q <= scl_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= {q[STAGES-2:0], scl_i};
      end
    end
  endgenerate

  assign scl_o = q[STAGES-1];
endmodule

// File: rtl/i2cs_hold_ctrl.sv
module i2cs_hold_ctrl
  import i2cs_stretch_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic byte_done_i,
  input  logic rel_we_i,
  input  logic rel_wdata_i,
  input  logic scl_low_i,
  output logic scl_oe_o,
  output logic rel_o
);
  hold_st_e st_q, st_d;
  logic     hold_req;

  // hardware clear beats a software release on the same edge
  assign hold_req = byte_done_i || (rel_we_i && !rel_wdata_i && st_q == ST_FREE);

  always_comb begin
    st_d = st_q;
    if (hold_req) begin
      if (st_q != ST_HOLD) st_d = scl_low_i ? ST_HOLD : ST_ARM;
    end else if (rel_we_i && rel_wdata_i) begin
      st_d = ST_FREE;
    end else if (st_q == ST_ARM && scl_low_i) begin
      st_d = ST_HOLD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_FREE;
    else         st_q <= st_d;
  end

  assign scl_oe_o = (st_q == ST_HOLD);
  assign rel_o    = (st_q == ST_FREE);
endmodule

// File: rtl/i2cs_irq_flag.sv
module i2cs_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/i2cs_tx_buf.sv
module i2cs_tx_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              open_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              data_o <= '0;
    else if (we_i && open_i)  data_o <= wdata_i;
  end
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              byte_done_i,
  input  logic              buf_we_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              rel_we_i,
  input  logic              rel_wdata_i,
  input  logic              irq_clr_i,
  output logic              scl_oe_o,
  output logic              rel_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] tx_data_o
);
  logic scl_sync;

  i2cs_scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .scl_i (scl_i),
    .scl_o (scl_sync)
  );

  i2cs_hold_ctrl u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_done_i(byte_done_i),
    .rel_we_i   (rel_we_i),
    .rel_wdata_i(rel_wdata_i),
    .scl_low_i  (!scl_sync),
    .scl_oe_o   (scl_oe_o),
    .rel_o      (rel_o)
  );

  i2cs_irq_flag u_irq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (byte_done_i),
    .clr_i (irq_clr_i),
    .irq_o (irq_o)
  );

  i2cs_tx_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (buf_we_i),
    .open_i (!rel_o),
    .wdata_i(buf_wdata_i),
    .data_o (tx_data_o)
  );
endmodule

// File: rtl/i2cs_stretch_chk.sv
module i2cs_stretch_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_done_i,
  input logic              rel_we_i,
  input logic              rel_wdata_i,
  input logic              irq_clr_i,
  input logic              scl_sync,
  input logic              scl_oe_o,
  input logic              rel_o,
  input logic              irq_o,
  input logic [DATA_W-1:0] tx_data_o
);
  a_r2_done_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i |=> (!rel_o && irq_o));

  a_r3_hold_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && !(rel_we_i && rel_wdata_i)) |=> scl_oe_o);

  a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && rel_we_i && rel_wdata_i && !byte_done_i) |=> (!scl_oe_o && rel_o));

  a_r5_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  a_r6_done_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && rel_we_i && rel_wdata_i) |=> !rel_o);

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && irq_clr_i) |=> irq_o);

  a_r8_no_pull_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && scl_sync) |=> !scl_oe_o);

  a_r9_buf_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_o |=> $stable(tx_data_o));
endmodule

bind i2c_tgt_stretch i2cs_stretch_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .byte_done_i(byte_done_i),
  .rel_we_i   (rel_we_i),
  .rel_wdata_i(rel_wdata_i),
  .irq_clr_i  (irq_clr_i),
  .scl_sync   (scl_sync),
  .scl_oe_o   (scl_oe_o),
  .rel_o      (rel_o),
  .irq_o      (irq_o),
  .tx_data_o  (tx_data_o)
);

// File: tb/i2c_tgt_stretch_bench.sv
module i2c_tgt_stretch_bench;
  localparam int DW = 8;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          scl_m = 1'b1;
  logic          byte_done = 1'b0;
  logic          buf_we = 1'b0;
  logic [DW-1:0] buf_wdata = '0;
  logic          rel_we = 1'b0;
  logic          rel_wdata = 1'b0;
  logic          irq_clr = 1'b0;
  logic          scl_oe, rel, irq;
  logic [DW-1:0] tx_data;
  logic          scl_bus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  // wired-AND bus: master level and target pull-low
  assign scl_bus = scl_m & ~scl_oe;

  i2c_tgt_stretch #(.DATA_W(DW), .SYNC_STAGES(SYNC)) u_i2c_tgt_stretch (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .scl_i      (scl_bus),
    .byte_done_i(byte_done),
    .buf_we_i   (buf_we),
    .buf_wdata_i(buf_wdata),
    .rel_we_i   (rel_we),
    .rel_wdata_i(rel_wdata),
    .irq_clr_i  (irq_clr),
    .scl_oe_o   (scl_oe),
    .rel_o      (rel),
    .irq_o      (irq),
    .tx_data_o  (tx_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs set 1 time unit after a rising edge, results read 1 unit after the next
  task automatic tick();
    @(posedge clk);
    #1;
    byte_done = 1'b0; buf_we = 1'b0; rel_we = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic release_bus();
    rel_we = 1'b1; rel_wdata = 1'b1;
    tick();
  endtask

  task automatic settle_scl(input logic lvl);
    scl_m = lvl;
    for (int i = 0; i < SYNC + 1; i++) tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lens[8] = '{1, 2, 3, 5, 8, 17, 40, 100};
    #12;
    // R1 reset state
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 rel", int'(rel), 1);
    chk("R1 tx", int'(tx_data), 0);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    tick();

    settle_scl(1'b0);
    foreach (lens[k]) begin
      byte_done = 1'b1;
      tick();
      chk("R2 scl_oe", int'(scl_oe), 1);
      chk("R2 rel", int'(rel), 0);
      chk("R2 irq", int'(irq), 1);
      for (int c = 0; c < lens[k]; c++) begin
        if (c == 0) irq_clr = 1'b1;
        tick();
        chk("R3 hold", int'(scl_oe), 1);
        if (c == 0) chk("R5 irq cleared", int'(irq), 0);
      end
      buf_we = 1'b1; buf_wdata = DW'(k * 37 + 5);
      tick();
      chk("R9 accepted", int'(tx_data), (k * 37 + 5) % 256);
      release_bus();
      chk("R4 scl_oe", int'(scl_oe), 0);
      chk("R4 rel", int'(rel), 1);
      buf_we = 1'b1; buf_wdata = ~DW'(k * 37 + 5);
      tick();
      chk("R9 ignored", int'(tx_data), (k * 37 + 5) % 256);
    end

    // R11 write of zero during hold
    byte_done = 1'b1; tick();
    rel_we = 1'b1; rel_wdata = 1'b0; tick();
    chk("R11 scl_oe", int'(scl_oe), 1);
    chk("R11 rel", int'(rel), 0);
    release_bus();

    // R6 byte end and release on one edge
    byte_done = 1'b1; rel_we = 1'b1; rel_wdata = 1'b1;
    tick();
    chk("R6 rel", int'(rel), 0);
    chk("R6 scl_oe", int'(scl_oe), 1);

    // R7 byte end and flag clear on one edge
    byte_done = 1'b1; irq_clr = 1'b1;
    tick();
    chk("R7 irq", int'(irq), 1);
    release_bus();

    // R8 deferred pull while SCL high
    settle_scl(1'b1);
    byte_done = 1'b1; tick();
    chk("R8 rel", int'(rel), 0);
    chk("R8 irq", int'(irq), 1);
    chk("R8 no pull", int'(scl_oe), 0);
    tick(); tick();
    chk("R8 still no pull", int'(scl_oe), 0);
    scl_m = 1'b0;
    for (int e = 1; e <= SYNC + 1; e++) begin
      tick();
      chk("R8 pull timing", int'(scl_oe), (e == SYNC + 1) ? 1 : 0);
    end
    scl_m = 1'b1;
    tick();
    chk("R8 bus held", int'(scl_bus), 0);
    release_bus();

    // R10 software hold from free, flag untouched
    settle_scl(1'b0);
    irq_clr = 1'b1; tick();
    rel_we = 1'b1; rel_wdata = 1'b0; tick();
    chk("R10 scl_oe", int'(scl_oe), 1);
    chk("R10 rel", int'(rel), 0);
    chk("R10 irq", int'(irq), 0);

    // R9 full data sweep while held
    for (int v = 0; v < 256; v++) begin
      buf_we = 1'b1; buf_wdata = DW'(v);
      tick();
      chk("R9 sweep", int'(tx_data), v);
    end
    release_bus();
    for (int v = 0; v < 16; v++) begin
      buf_we = 1'b1; buf_wdata = DW'(v * 9);
      tick();
      chk("R9 locked", int'(tx_data), 255);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule